// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Detection

This block is a memory-mapped general-purpose I/O controller. It serves three banks of 32 pins each, so 96 pins in all. Global pin n lives in bank n / 32 at bit n % 32. Every pin has the following per-pin controls:

- a direction bit;
- an output latch, which can be loaded directly or changed bit by bit through separate set and clear words;
- a polarity bit, which inverts the pin as the controller sees it;
- four independent detect enables: rising edge, falling edge, high level and low level.

Pin inputs pass through a two-flop synchronizer before any use. Detected events latch into a per-bank status word, and software clears that word by writing ones. A second per-bank word records only the edge-caused events. A single interrupt line is raised while any status bit of any bank is set.

Software reaches the controller through a simple 32-bit bus. The bus has an address, a write strobe, a read strobe and write data. Read data is registered. Each function owns a 16-byte group of registers, and the register for bank b sits at the group base plus 4·b.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register is zero. All pins are inputs (`pin_oe` all zero), `pin_out` is zero and `irq` is low.
- R2: A word address is decoded as group base + 4·bank, where bank is 0..2 and must be word aligned. The group bases are:
  - 0x00 direction
  - 0x10 polarity
  - 0x20 data
  - 0x30 data set
  - 0x40 data clear
  - 0x50 rising enable
  - 0x60 falling enable
  - 0x70 high-level enable
  - 0x80 low-level enable
  - 0x90 interrupt status
  - 0xA0 edge status

  Any other address (bank field 3, group above 0xA0, nonzero bits 31:8 or 1:0) reads as zero, and writes to it change nothing.
- R3: `bus_rdata` carries the value addressed by a read strobe in the clock cycle after that strobe. The set and clear words read as zero.
- R4: A write to the data word loads the output latch. A write to the set word drives high each output bit written as 1, and a write to the clear word drives low each bit written as 1. Bits written as 0 keep their value.
- R5: A direction bit of 1 makes the pin an output and drives `pin_oe`. Reading the data word returns the output latch for output pins and the synchronized, polarity-adjusted input for input pins.
- R6: Inputs pass through two flops. An input change presented before clock edge k sets the status bit at edge k+2, so `irq` follows after edge k+2 and not before.
- R7: The rising and falling enables are independent. With both set, the pin flags on either edge. An edge event sets both the interrupt-status bit and the edge-status bit.
- R8: A high-level (low-level) enabled pin sets its status bit on every cycle its adjusted level is 1 (0). It does not set its edge-status bit.
- R9: The status and edge-status words are write-one-to-clear, and bits written as 0 are unchanged. When a detection and a clear hit the same bit in one cycle, the bit stays set.
- R10: A pin whose four enables are all clear never sets a status bit.
- R11: `irq` is high exactly while at least one interrupt-status bit in any bank is set.
- R12: A polarity bit of 1 inverts the pin before edge detection, level detection and the data-word read. A polarity of 0 leaves it uninverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | 96 | Raw pin inputs, bank 0 in bits 31:0 |
| pin_out | output | 96 | Output latch values |
| pin_oe | output | 96 | Output enables (direction bits) |
| irq | output | 1 | Shared interrupt, high while any status bit is set |

## Verification
Two functions can land on the same status bit in one cycle: a detection setting it and a bus write-one clearing it. The bench provokes this by holding a high-level-enabled pin high while software writes a 1 to its status bit. The detection is then active on exactly the edge where the clear lands, and the read-back must still show the bit set. The contrasting case removes the level first, then repeats the clear and expects zero. The bench also judges the set and clear words against a direct data load by reading the resulting output latch back through the data word.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  // Function groups; the value is address bits 7:4.
  typedef enum logic [3:0] {
    GRP_DIR  = 4'h0,
    GRP_POL  = 4'h1,
    GRP_DATA = 4'h2,
    GRP_SET  = 4'h3,
    GRP_CLR  = 4'h4,
    GRP_RISE = 4'h5,
    GRP_FALL = 4'h6,
    GRP_HIGH = 4'h7,
    GRP_LOW  = 4'h8,
    GRP_STAT = 4'h9,
    GRP_EDGE = 4'hA
  } grp_e;

  localparam int unsigned GRP_COUNT = 11;

  typedef struct packed {
    logic       hit;
    grp_e       grp;
    logic [1:0] bank;
  } dec_t;

  // Group in bits 7:4, bank in bits 3:2; everything else must be zero.
  function automatic dec_t decode_addr(input logic [31:0] a, input int unsigned nbanks);
    dec_t d;
    d.grp  = grp_e'(a[7:4]);
    d.bank = a[3:2];
    d.hit  = (a[31:8] == 24'h0) && (a[1:0] == 2'b00) &&
             (a[7:4] < 4'(GRP_COUNT)) && (32'(a[3:2]) < nbanks);
    return d;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GRP_COUNT-1:0] wr_grp,
  input  logic [W-1:0]         wdata,
  input  logic [W-1:0]         pin_sync,
  output logic [W-1:0]         dir_q,
  output logic [W-1:0]         pol_q,
  output logic [W-1:0]         out_q,
  output logic [W-1:0]         rise_en_q,
  output logic [W-1:0]         fall_en_q,
  output logic [W-1:0]         high_en_q,
  output logic [W-1:0]         low_en_q,
  output logic [W-1:0]         stat_q,
  output logic [W-1:0]         edge_q,
  output logic [W-1:0]         data_view,
  output logic [W-1:0]         set_ev,
  output logic [W-1:0]         edge_ev
);
  localparam int unsigned NCFG = 6;
  localparam int CFG_IDX [NCFG] = '{0, 1, 5, 6, 7, 8};

  logic [W-1:0] cfg_q [NCFG];
  logic [W-1:0] lvl, prev_q, lvl_ev;

  // Plain read/write configuration words.
  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cfg_q[k] <= '0;
      else if (wr_grp[CFG_IDX[k]])    cfg_q[k] <= wdata;
    end
  end

  assign dir_q     = cfg_q[0];
  assign pol_q     = cfg_q[1];
  assign rise_en_q = cfg_q[2];
  assign fall_en_q = cfg_q[3];
  assign high_en_q = cfg_q[4];
  assign low_en_q  = cfg_q[5];

  function automatic logic [W-1:0] next_out(input logic [W-1:0] cur, input logic [W-1:0] wd,
                                            input logic ld, input logic st, input logic cl);
    if (ld) return wd;
    return (cur | (st ? wd : '0)) & ~(cl ? wd : '0);
  endfunction

  function automatic logic [W-1:0] w1c(input logic [W-1:0] cur, input logic [W-1:0] wd,
                                       input logic cl, input logic [W-1:0] setv);
    return (cur & ~(cl ? wd : '0)) | setv;
  endfunction

  // Adjusted level and detection.
  assign lvl     = pin_sync ^ pol_q;
  assign edge_ev = (lvl & ~prev_q & rise_en_q) | (~lvl & prev_q & fall_en_q);
  assign lvl_ev  = (lvl & high_en_q) | (~lvl & low_en_q);
  assign set_ev  = edge_ev | lvl_ev;

  assign data_view = (dir_q & out_q) | (~dir_q & lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      out_q  <= '0;
      stat_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= lvl;
      out_q  <= next_out(out_q, wdata, wr_grp[GRP_DATA], wr_grp[GRP_SET], wr_grp[GRP_CLR]);
      stat_q <= w1c(stat_q, wdata, wr_grp[GRP_STAT], set_ev);
      edge_q <= w1c(edge_q, wdata, wr_grp[GRP_EDGE], edge_ev);
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned PIN_W     = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  output logic              irq
);
  dec_t dec;
  logic map_ok;
  logic [PIN_W-1:0] pin_s;

  logic [GRP_COUNT-1:0] wr_grp [NUM_BANKS];
  logic [BANK_W-1:0] dir_a [NUM_BANKS], pol_a [NUM_BANKS], out_a [NUM_BANKS];
  logic [BANK_W-1:0] rise_a [NUM_BANKS], fall_a [NUM_BANKS], high_a [NUM_BANKS];
  logic [BANK_W-1:0] low_a [NUM_BANKS], stat_a [NUM_BANKS], edge_a [NUM_BANKS];
  logic [BANK_W-1:0] view_a [NUM_BANKS], sev_a [NUM_BANKS], eev_a [NUM_BANKS];

  // Named internal events for the checker.
  logic [PIN_W-1:0] stat_flat, set_ev_flat, en_any_flat, out_flat, dir_flat;
  logic [PIN_W-1:0] set_mask_flat, clr_mask_flat;

  assign dec    = decode_addr(bus_addr, NUM_BANKS);
  assign map_ok = dec.hit;

  gpio_sync #(.W(PIN_W)) u_sync (.clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign wr_grp[b] = (bus_wr && dec.hit && (dec.bank == 2'(b)))
                       ? (GRP_COUNT'(1) << dec.grp) : '0;

    gpio_bank #(.W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_grp(wr_grp[b]), .wdata(bus_wdata),
      .pin_sync(pin_s[b*BANK_W +: BANK_W]),
      .dir_q(dir_a[b]), .pol_q(pol_a[b]), .out_q(out_a[b]),
      .rise_en_q(rise_a[b]), .fall_en_q(fall_a[b]), .high_en_q(high_a[b]),
      .low_en_q(low_a[b]), .stat_q(stat_a[b]), .edge_q(edge_a[b]),
      .data_view(view_a[b]), .set_ev(sev_a[b]), .edge_ev(eev_a[b])
    );

    assign stat_flat[b*BANK_W +: BANK_W]     = stat_a[b];
    assign set_ev_flat[b*BANK_W +: BANK_W]   = sev_a[b];
    assign en_any_flat[b*BANK_W +: BANK_W]   = rise_a[b] | fall_a[b] | high_a[b] | low_a[b];
    assign out_flat[b*BANK_W +: BANK_W]      = out_a[b];
    assign dir_flat[b*BANK_W +: BANK_W]      = dir_a[b];
    assign set_mask_flat[b*BANK_W +: BANK_W] = wr_grp[b][GRP_SET] ? bus_wdata : '0;
    assign clr_mask_flat[b*BANK_W +: BANK_W] = wr_grp[b][GRP_CLR] ? bus_wdata : '0;
  end

  assign pin_out = out_flat;
  assign pin_oe  = dir_flat;
  assign irq     = |stat_flat;

  // Read mux: one bank chosen, then one group.
  logic [1:0]  bsel;
  logic [31:0] rd_val;
  assign bsel = dec.bank;

  always_comb begin
    rd_val = '0;
    if (dec.hit) begin
      case (dec.grp)
        GRP_DIR:  rd_val = dir_a[bsel];
        GRP_POL:  rd_val = pol_a[bsel];
        GRP_DATA: rd_val = view_a[bsel];
        GRP_RISE: rd_val = rise_a[bsel];
        GRP_FALL: rd_val = fall_a[bsel];
        GRP_HIGH: rd_val = high_a[bsel];
        GRP_LOW:  rd_val = low_a[bsel];
        GRP_STAT: rd_val = stat_a[bsel];
        GRP_EDGE: rd_val = edge_a[bsel];
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int unsigned PIN_W = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             map_ok,
  input logic [31:0]      bus_rdata,
  input logic [PIN_W-1:0] pin_oe,
  input logic             irq,
  input logic [PIN_W-1:0] stat_flat,
  input logic [PIN_W-1:0] set_ev_flat,
  input logic [PIN_W-1:0] en_any_flat,
  input logic [PIN_W-1:0] out_flat,
  input logic [PIN_W-1:0] set_mask_flat,
  input logic [PIN_W-1:0] clr_mask_flat
);
  p_rst_inputs_r1: assert property (@(posedge clk) !rst_n |=> (pin_oe == '0));

  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !map_ok) |=> (bus_rdata == '0));

  p_set_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask_flat != '0) |=> ((out_flat & $past(set_mask_flat)) == $past(set_mask_flat)));

  p_clr_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask_flat != '0) |=> ((out_flat & $past(clr_mask_flat)) == '0));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev_flat != '0) |=> ((stat_flat & $past(set_ev_flat)) == $past(set_ev_flat)));

  p_no_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_ev_flat & ~en_any_flat) == '0));

  p_irq_any_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (stat_flat != '0));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .map_ok(map_ok), .bus_rdata(bus_rdata),
  .pin_oe(pin_oe), .irq(irq), .stat_flat(stat_flat), .set_ev_flat(set_ev_flat),
  .en_any_flat(en_any_flat), .out_flat(out_flat),
  .set_mask_flat(set_mask_flat), .clr_mask_flat(clr_mask_flat)
);

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
  localparam int unsigned PIN_W = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [PIN_W-1:0] pin_in = '0;
  logic [PIN_W-1:0] pin_out, pin_oe;
  logic irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_bank_ctrl i_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // Group bases (R2)
  localparam logic [31:0] A_DIR = 32'h00, A_POL = 32'h10, A_DATA = 32'h20, A_SET = 32'h30,
                          A_CLR = 32'h40, A_RISE = 32'h50, A_FALL = 32'h60, A_HIGH = 32'h70,
                          A_LOW = 32'h80, A_STAT = 32'h90, A_EDGE = 32'hA0;

  function automatic logic [31:0] ra(input logic [31:0] base, input int bank);
    return base + 32'(bank * 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 pin_oe lo", pin_oe[31:0], 32'h0);
    check("R1 pin_oe hi", pin_oe[95:64], 32'h0);
    check("R1 pin_out", pin_out[63:32], 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd(ra(A_DIR, 0), v);  check("R1 dir0", v, 32'h0);
    rd(ra(A_STAT, 2), v); check("R1 stat2", v, 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(ra(A_DIR, 1), 32'hA5A5_0000);
    rd(ra(A_DIR, 1), v); check("R2 R3 dir1 readback", v, 32'hA5A5_0000);
    rd(ra(A_DIR, 0), v); check("R2 dir0 untouched", v, 32'h0);
    rd(ra(A_DIR, 2), v); check("R2 dir2 untouched", v, 32'h0);
    check("R5 pin_oe bank1", pin_oe[63:32], 32'hA5A5_0000);
    wr(ra(A_DIR, 1), 32'h0);
    wr(ra(A_SET, 0), 32'h0000_0001);
    rd(ra(A_SET, 0), v); check("R3 set word reads zero", v, 32'h0);
    wr(ra(A_CLR, 0), 32'h0000_0001);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(32'h0000_000C, 32'hFFFF_FFFF);
    wr(32'h0000_0001, 32'hFFFF_FFFF);
    wr(32'h0000_0100, 32'hFFFF_FFFF);
    rd(32'h0000_000C, v); check("R2 bank3 reads zero", v, 32'h0);
    rd(32'h0000_00B0, v); check("R2 high group zero", v, 32'h0);
    rd(32'h0000_0100, v); check("R2 upper bits zero", v, 32'h0);
    check("R2 writes ignored oe lo", pin_oe[31:0], 32'h0);
    check("R2 writes ignored oe mid", pin_oe[63:32], 32'h0);
    check("R2 writes ignored oe hi", pin_oe[95:64], 32'h0);
  endtask

  task automatic t_setclr;
    logic [31:0] v;
    wr(ra(A_DIR, 0), 32'hFFFF_FFFF);
    wr(ra(A_DATA, 0), 32'h0000_00F0);
    wr(ra(A_SET, 0), 32'h0000_000F);
    rd(ra(A_DATA, 0), v); check("R4 set word", v, 32'h0000_00FF);
    check("R4 pin_out after set", pin_out[31:0], 32'h0000_00FF);
    wr(ra(A_CLR, 0), 32'h0000_0030);
    rd(ra(A_DATA, 0), v); check("R4 clear word", v, 32'h0000_00CF);
    wr(ra(A_DATA, 0), 32'h0);
    wr(ra(A_DIR, 0), 32'h0);
  endtask

  task automatic t_dir_read;
    logic [31:0] v;
    wr(ra(A_DIR, 2), 32'h0000_FFFF);
    wr(ra(A_DATA, 2), 32'h1234_5678);
    pin_in[95:64] = 32'hAAAA_5555;
    idle(4);
    rd(ra(A_DATA, 2), v); check("R5 mixed data read", v, 32'hAAAA_5678);
    check("R5 pin_oe bank2", pin_oe[95:64], 32'h0000_FFFF);
    wr(ra(A_DIR, 2), 32'h0);
    wr(ra(A_DATA, 2), 32'h0);
    pin_in[95:64] = '0;
    idle(4);
  endtask

  task automatic t_rise;
    logic [31:0] v;
    wr(ra(A_RISE, 0), 32'h0000_0008);
    @(negedge clk);
    pin_in[3] = 1'b1;
    @(negedge clk); check("R6 irq not after 1 edge", {31'h0, irq}, 32'h0);
    @(negedge clk); check("R6 irq not after 2 edges", {31'h0, irq}, 32'h0);
    @(negedge clk); check("R6 irq after 3 edges", {31'h0, irq}, 32'h1);
    rd(ra(A_STAT, 0), v); check("R7 rise status", v, 32'h0000_0008);
    rd(ra(A_EDGE, 0), v); check("R7 rise edge status", v, 32'h0000_0008);
    wr(ra(A_STAT, 0), 32'h0);
    rd(ra(A_STAT, 0), v); check("R9 zero write keeps bit", v, 32'h0000_0008);
    wr(ra(A_STAT, 0), 32'h0000_0008);
    wr(ra(A_EDGE, 0), 32'h0000_0008);
    rd(ra(A_STAT, 0), v); check("R9 w1c status", v, 32'h0);
    rd(ra(A_EDGE, 0), v); check("R9 w1c edge status", v, 32'h0);
    check("R11 irq low after clear", {31'h0, irq}, 32'h0);
    pin_in[3] = 1'b0;
    idle(4);
    rd(ra(A_STAT, 0), v); check("R7 falling ignored by rise-only", v, 32'h0);
    wr(ra(A_RISE, 0), 32'h0);
  endtask

  task automatic t_both;
    logic [31:0] v;
    wr(ra(A_RISE, 1), 32'h0000_0080);
    wr(ra(A_FALL, 1), 32'h0000_0180);
    pin_in[32+7] = 1'b1;
    idle(4);
    rd(ra(A_STAT, 1), v); check("R7 both: rise flagged", v, 32'h0000_0080);
    wr(ra(A_STAT, 1), 32'hFFFF_FFFF);
    pin_in[32+7] = 1'b0;
    idle(4);
    rd(ra(A_STAT, 1), v); check("R7 both: fall flagged", v, 32'h0000_0080);
    wr(ra(A_STAT, 1), 32'hFFFF_FFFF);
    pin_in[32+8] = 1'b1;
    idle(4);
    rd(ra(A_STAT, 1), v); check("R7 fall-only ignores rise", v, 32'h0);
    pin_in[32+8] = 1'b0;
    idle(4);
    rd(ra(A_STAT, 1), v); check("R7 fall-only flags fall", v, 32'h0000_0100);
    wr(ra(A_RISE, 1), 32'h0);
    wr(ra(A_FALL, 1), 32'h0);
    wr(ra(A_STAT, 1), 32'hFFFF_FFFF);
    wr(ra(A_EDGE, 1), 32'hFFFF_FFFF);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(ra(A_HIGH, 2), 32'h0000_0001);
    pin_in[64] = 1'b1;
    idle(4);
    rd(ra(A_STAT, 2), v); check("R8 high level flags", v, 32'h0000_0001);
    rd(ra(A_EDGE, 2), v); check("R8 level leaves edge status", v, 32'h0);
    wr(ra(A_STAT, 2), 32'h0000_0001);
    rd(ra(A_STAT, 2), v); check("R9 set wins over clear", v, 32'h0000_0001);
    pin_in[64] = 1'b0;
    idle(4);
    wr(ra(A_STAT, 2), 32'h0000_0001);
    rd(ra(A_STAT, 2), v); check("R8 clear sticks once level gone", v, 32'h0);
    wr(ra(A_HIGH, 2), 32'h0);
    wr(ra(A_LOW, 2), 32'h0000_0002);
    idle(2);
    rd(ra(A_STAT, 2), v); check("R8 low level flags", v, 32'h0000_0002);
    wr(ra(A_LOW, 2), 32'h0);
    wr(ra(A_STAT, 2), 32'hFFFF_FFFF);
  endtask

  task automatic t_no_enable;
    logic [31:0] v;
    pin_in[63:48] = 16'hFFFF;
    idle(4);
    pin_in[63:48] = 16'h0;
    idle(4);
    rd(ra(A_STAT, 1), v); check("R10 no enables no status", v, 32'h0);
    rd(ra(A_EDGE, 1), v); check("R10 no enables no edge status", v, 32'h0);
    check("R10 irq stays low", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_irq_banks;
    logic [31:0] v;
    wr(ra(A_HIGH, 2), 32'h0000_0020);
    wr(ra(A_RISE, 0), 32'h0000_0001);
    pin_in[64+5] = 1'b1;
    pin_in[0] = 1'b1;
    idle(4);
    check("R11 irq with two banks", {31'h0, irq}, 32'h1);
    wr(ra(A_STAT, 0), 32'h0000_0001);
    idle(1);
    check("R11 irq held by bank2", {31'h0, irq}, 32'h1);
    pin_in[64+5] = 1'b0;
    idle(4);
    wr(ra(A_STAT, 2), 32'h0000_0020);
    idle(1);
    check("R11 irq low when all clear", {31'h0, irq}, 32'h0);
    wr(ra(A_HIGH, 2), 32'h0);
    wr(ra(A_RISE, 0), 32'h0);
    wr(ra(A_EDGE, 0), 32'hFFFF_FFFF);
    pin_in[0] = 1'b0;
    idle(4);
    rd(ra(A_STAT, 0), v); check("R11 bank0 clean", v, 32'h0);
  endtask

  task automatic t_polarity;
    logic [31:0] v;
    wr(ra(A_POL, 0), 32'h0000_0200);
    idle(2);
    rd(ra(A_DATA, 0), v); check("R12 inverted input read", v, 32'h0000_0200);
    wr(ra(A_HIGH, 0), 32'h0000_0200);
    idle(2);
    rd(ra(A_STAT, 0), v); check("R12 inverted level flags", v, 32'h0000_0200);
    pin_in[9] = 1'b1;
    idle(4);
    wr(ra(A_STAT, 0), 32'h0000_0200);
    rd(ra(A_STAT, 0), v); check("R12 high pin reads as low level", v, 32'h0);
    wr(ra(A_HIGH, 0), 32'h0);
    wr(ra(A_POL, 0), 32'h0);
    idle(2);
    rd(ra(A_DATA, 0), v); check("R12 zero polarity not inverted", v, 32'h0000_0200);
    pin_in[9] = 1'b0;
    idle(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_map();
    t_unmapped();
    t_setclr();
    t_dir_read();
    t_rise();
    t_both();
    t_level();
    t_no_enable();
    t_irq_banks();
    t_polarity();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule